// File: doc/BRIEF.md
# Video Timing Generator

This block produces the raster timing for a parallel RGB display: horizontal and vertical sync, a data-enable that marks visible pixels, and the current pixel and line position. A programmable divider turns the fast video clock into a single-cycle pixel clock enable, and every timing state change happens only on that enable. Each line passes through four regions in a fixed order (sync, back porch, active, front porch). A frame passes through the same four regions counted in lines.

Every porch, sync width and active size is supplied as its count minus one, so a field of zero means one pixel or one line. The divider value is also the divisor minus one and saturates so that the divisor never exceeds 255. Two enables control output. The video enable starts and stops the counters at once. The frame enable gates data-enable and is sampled only at the start of a frame. A sticky frame interrupt can be raised when the raster enters a chosen vertical region, and a write-one-to-clear input removes it. A comparator flags the active line that matches a programmed threshold.

Top module: `vid_timing_gen`

## Requirements
- R1: While reset is held, and on the first sample after its release with all inputs low, pix_ce, hsync, vsync, de, lc_hit and irq are 0 and hpos and vpos are 0.
- R2: With the divider running and not held, pix_ce is high for one clock out of every (div_m1 + 1) clocks. The value 255 in div_m1 is treated as 254, so the longest period is 255 clocks.
- R3: While clk_hold is high, pix_ce is 0 and the divider count is frozen. The divider runs when vid_en or free_run is high. With both low, pix_ce is 0 and the count returns to zero.
- R4: hpos advances by one on each pix_ce while vid_en is high. It wraps to 0 after h_sync_m1 + h_back_m1 + h_act_m1 + h_front_m1 + 3. hsync is high exactly for hpos 0 to h_sync_m1.
- R5: vpos advances by one each time hpos wraps. It wraps to 0 after the sum of the four vertical fields plus 3. vsync is high exactly for vpos 0 to v_sync_m1.
- R6: de is high only when hpos lies in [h_sync_m1+h_back_m1+2, that + h_act_m1] and vpos lies in the matching vertical window and the latched frame enable is set.
- R7: vid_en_frame is latched at a frame start: the clock where vid_en first rises, or the clock after the counters step to hpos 0, vpos 0. A change at any other time has no effect on de until that point.
- R8: With vid_en low, hpos and vpos are held at 0 and hsync, vsync, de and lc_hit are 0.
- R9: lc_hit is high while vpos is in the active window and (vpos minus the first active line) equals lc_thresh.
- R10: With irq_en high, irq is set one clock after the counters step to hpos 0 on the first line of the region chosen by irq_sel (0 sync, 1 back porch, 2 active, 3 front porch). It stays set until a clock with irq_clr high and no new event; a new event wins over a clear.
- R11: With irq_en low, irq does not become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_en | input | 1 | Video enable, immediate |
| vid_en_frame | input | 1 | Frame-synchronised output enable |
| free_run | input | 1 | Keep the divider running while video is off |
| clk_hold | input | 1 | Freeze the pixel clock enable |
| div_m1 | input | 8 | Pixel clock divisor minus one |
| h_sync_m1 | input | 11 | Hsync width minus one, in pixels |
| h_back_m1 | input | 11 | Horizontal back porch minus one |
| h_act_m1 | input | 11 | Active width minus one |
| h_front_m1 | input | 11 | Horizontal front porch minus one |
| v_sync_m1 | input | 11 | Vsync width minus one, in lines |
| v_back_m1 | input | 11 | Vertical back porch minus one |
| v_act_m1 | input | 11 | Active height minus one |
| v_front_m1 | input | 11 | Vertical front porch minus one |
| lc_thresh | input | 11 | Active line index compared for lc_hit |
| irq_en | input | 1 | Frame interrupt enable |
| irq_sel | input | 2 | Vertical region that raises the interrupt |
| irq_clr | input | 1 | Write-one-to-clear for the pending interrupt |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| hpos | output | 13 | Current pixel position in the line |
| vpos | output | 13 | Current line position in the frame |
| lc_hit | output | 1 | Line-count threshold flag |
| irq | output | 1 | Pending frame interrupt |

## Verification
On every cycle the assertions check a set of local invariants. The counters wrap to zero after their last position and hold still between steps. Data-enable never overlaps a sync pulse. The held or idle divider issues no enable, and back-to-back enables do not occur above divisor one. The latched frame enable moves only at a frame start. The pending interrupt holds without a clear and stays low while disabled. Exact region lengths, divider periods, interrupt timing per region select, threshold line matching and the frame-boundary sampling of the frame enable depend on the programmed values. Only the bench scenarios show these, by comparing each cycle against an independent model.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   // Region order within a line and within a frame; irq_sel decodes to this.
   typedef enum logic [1:0] {
      RG_SYNC  = 2'd0,
      RG_BACK  = 2'd1,
      RG_ACT   = 2'd2,
      RG_FRONT = 2'd3
   } vtg_region_e;

   localparam int unsigned NUM_REGIONS = 4;

endpackage

// File: rtl/vtg_clkdiv.sv
module vtg_clkdiv #(
   parameter int unsigned DW       = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          hold,
   input  logic [DW-1:0] div_m1,
   output logic          pix_ce
);

   localparam logic [DW-1:0] TC_SAT = DW'((1 << DW) - 2);

   if (DW < 2) begin : g_bad_dw
      $error("vtg_clkdiv: DW must be at least 2");
   end

   logic [DW-1:0] tc;
   logic [DW-1:0] cnt_q;

   // Terminal count: saturating variant caps the divisor one below full scale.
   if (SATURATE) begin : g_sat
      assign tc = (div_m1 == '1) ? TC_SAT : div_m1;
   end else begin : g_nosat
      assign tc = div_m1;
   end

   assign pix_ce = run && !hold && (cnt_q >= tc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (hold) begin
         cnt_q <= cnt_q;
      end else if (pix_ce) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DW'(1);
      end
   end

   p_hold_freeze_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(cnt_q));
   p_idle_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
   p_ce_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ce && tc != '0 && run) |=> !pix_ce);

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
   import vtg_pkg::*;
#(
   parameter int unsigned CW = 11,
   parameter int unsigned PW = CW + 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr,
   input  logic                            adv,
   input  logic [CW-1:0]                   sync_m1,
   input  logic [CW-1:0]                   back_m1,
   input  logic [CW-1:0]                   act_m1,
   input  logic [CW-1:0]                   front_m1,
   output logic [PW-1:0]                   pos,
   output logic                            wrap,
   output logic                            in_sync,
   output logic                            in_act,
   output logic [PW-1:0]                   act_idx,
   output logic [NUM_REGIONS-1:0][PW-1:0]  starts
);

   localparam int unsigned TW = PW + 1;

   if (PW < CW + 2) begin : g_bad_pw
      $error("vtg_axis: PW must hold four regions of CW bits");
   end

   logic [NUM_REGIONS-1:0][CW-1:0] fld;
   logic [NUM_REGIONS-1:0][TW-1:0] st_w;
   logic [TW-1:0]                  total;
   logic [PW-1:0]                  pos_q;

   assign fld[RG_SYNC]  = sync_m1;
   assign fld[RG_BACK]  = back_m1;
   assign fld[RG_ACT]   = act_m1;
   assign fld[RG_FRONT] = front_m1;

   // Each region begins where the previous one ends.
   assign st_w[0] = '0;
   for (genvar i = 1; i < NUM_REGIONS; i++) begin : g_start
      assign st_w[i] = st_w[i-1] + TW'(fld[i-1]) + TW'(1);
   end
   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_start_out
      assign starts[i] = st_w[i][PW-1:0];
   end

   assign total   = st_w[NUM_REGIONS-1] + TW'(fld[NUM_REGIONS-1]) + TW'(1);
   assign wrap    = adv && (TW'(pos_q) >= total - TW'(1));
   assign pos     = pos_q;
   assign in_sync = (TW'(pos_q) < st_w[RG_BACK]);
   assign in_act  = (TW'(pos_q) >= st_w[RG_ACT]) && (TW'(pos_q) < st_w[RG_FRONT]);
   assign act_idx = pos_q - starts[RG_ACT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (clr) begin
         pos_q <= '0;
      end else if (adv) begin
         pos_q <= wrap ? '0 : pos_q + PW'(1);
      end
   end

   p_wrap_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !clr) |=> (pos_q == '0));
   p_idle_stable_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(pos_q));
   p_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pos_q == '0));

endmodule

// File: rtl/vtg_irq.sv
module vtg_irq
   import vtg_pkg::*;
#(
   parameter int unsigned PW = 13
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic                           adv,
   input  logic [PW-1:0]                  hpos,
   input  logic [PW-1:0]                  vpos,
   input  logic [NUM_REGIONS-1:0][PW-1:0] vstarts,
   input  logic                           irq_en,
   input  vtg_region_e                    irq_sel,
   input  logic                           irq_clr,
   output logic                           frame_tick,
   output logic                           irq
);

   logic step_q;
   logic line_head;
   logic event_hit;
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= adv;
   end

   // The cycle right after a step that landed on pixel 0 of a line.
   assign line_head  = en && step_q && (hpos == '0);
   assign frame_tick = line_head && (vpos == '0);
   assign event_hit  = line_head && (vpos == vstarts[irq_sel]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (irq_en && event_hit) begin
         pend_q <= 1'b1;
      end else if (irq_clr) begin
         pend_q <= 1'b0;
      end
   end

   assign irq = pend_q;

   p_irq_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   p_irq_masked_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !irq) |=> !irq);

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int unsigned H_W       = 11,
   parameter int unsigned V_W       = 11,
   parameter int unsigned DIV_W     = 8,
   parameter bit          DIV_SAT   = 1'b1,
   parameter bit          SYNC_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vid_en,
   input  logic             vid_en_frame,
   input  logic             free_run,
   input  logic             clk_hold,
   input  logic [DIV_W-1:0] div_m1,
   input  logic [H_W-1:0]   h_sync_m1,
   input  logic [H_W-1:0]   h_back_m1,
   input  logic [H_W-1:0]   h_act_m1,
   input  logic [H_W-1:0]   h_front_m1,
   input  logic [V_W-1:0]   v_sync_m1,
   input  logic [V_W-1:0]   v_back_m1,
   input  logic [V_W-1:0]   v_act_m1,
   input  logic [V_W-1:0]   v_front_m1,
   input  logic [V_W-1:0]   lc_thresh,
   input  logic             irq_en,
   input  logic [1:0]       irq_sel,
   input  logic             irq_clr,
   output logic             pix_ce,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [H_W+1:0]   hpos,
   output logic [V_W+1:0]   vpos,
   output logic             lc_hit,
   output logic             irq
);

   localparam int unsigned HPW = H_W + 2;
   localparam int unsigned VPW = V_W + 2;

   if (H_W < 2 || V_W < 2) begin : g_bad_w
      $error("vid_timing_gen: H_W and V_W must be at least 2");
   end

   logic                            adv_h;
   logic                            h_wrap, v_wrap;
   logic                            h_sync_raw, v_sync_raw;
   logic                            h_act, v_act;
   logic [HPW-1:0]                  h_idx;
   logic [VPW-1:0]                  v_idx;
   logic [NUM_REGIONS-1:0][HPW-1:0] h_starts;
   logic [NUM_REGIONS-1:0][VPW-1:0] v_starts;
   logic                            run_q;
   logic                            fen_q;
   logic                            frame_tick;
   logic                            frame_start;

   vtg_clkdiv #(.DW(DIV_W), .SATURATE(DIV_SAT)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (vid_en | free_run),
      .hold   (clk_hold),
      .div_m1 (div_m1),
      .pix_ce (pix_ce)
   );

   assign adv_h = vid_en && pix_ce;

   vtg_axis #(.CW(H_W), .PW(HPW)) u_hax (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!vid_en),
      .adv      (adv_h),
      .sync_m1  (h_sync_m1),
      .back_m1  (h_back_m1),
      .act_m1   (h_act_m1),
      .front_m1 (h_front_m1),
      .pos      (hpos),
      .wrap     (h_wrap),
      .in_sync  (h_sync_raw),
      .in_act   (h_act),
      .act_idx  (h_idx),
      .starts   (h_starts)
   );

   vtg_axis #(.CW(V_W), .PW(VPW)) u_vax (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!vid_en),
      .adv      (h_wrap),
      .sync_m1  (v_sync_m1),
      .back_m1  (v_back_m1),
      .act_m1   (v_act_m1),
      .front_m1 (v_front_m1),
      .pos      (vpos),
      .wrap     (v_wrap),
      .in_sync  (v_sync_raw),
      .in_act   (v_act),
      .act_idx  (v_idx),
      .starts   (v_starts)
   );

   vtg_irq #(.PW(VPW)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (vid_en),
      .adv        (adv_h),
      .hpos       (HPW'(hpos)),
      .vpos       (vpos),
      .vstarts    (v_starts),
      .irq_en     (irq_en),
      .irq_sel    (vtg_region_e'(irq_sel)),
      .irq_clr    (irq_clr),
      .frame_tick (frame_tick),
      .irq        (irq)
   );

   // Frame-synchronised enable: sampled on enable rise or at each frame start.
   assign frame_start = (vid_en && !run_q) || frame_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         fen_q <= 1'b0;
      end else begin
         run_q <= vid_en;
         if (frame_start) fen_q <= vid_en_frame;
      end
   end

   logic hs_on, vs_on;
   assign hs_on = vid_en && h_sync_raw;
   assign vs_on = vid_en && v_sync_raw;

   if (SYNC_HIGH) begin : g_pol_high
      assign hsync = hs_on;
      assign vsync = vs_on;
   end else begin : g_pol_low
      assign hsync = !hs_on;
      assign vsync = !vs_on;
   end

   assign de     = vid_en && fen_q && h_act && v_act;
   assign lc_hit = vid_en && v_act && (v_idx == VPW'(lc_thresh));

   logic unused_ok;
   assign unused_ok = &{1'b0, v_wrap, h_idx};

   p_de_no_sync_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hs_on && !vs_on));
   p_fen_frame_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(fen_q));
   p_lc_active_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      lc_hit |-> v_act);
   p_off_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !vid_en |-> (!de && !lc_hit && !hs_on && !vs_on));

endmodule

// File: tb/tb_vid_timing_gen.sv
module tb_vid_timing_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vid_en = 0, vid_en_frame = 0, free_run = 0, clk_hold = 0;
   logic [7:0]  div_m1 = 0;
   logic [10:0] h_sync_m1 = 0, h_back_m1 = 0, h_act_m1 = 0, h_front_m1 = 0;
   logic [10:0] v_sync_m1 = 0, v_back_m1 = 0, v_act_m1 = 0, v_front_m1 = 0;
   logic [10:0] lc_thresh = 0;
   logic        irq_en = 0, irq_clr = 0;
   logic [1:0]  irq_sel = 0;
   logic        pix_ce, hsync, vsync, de, lc_hit, irq;
   logic [12:0] hpos, vpos;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   vid_timing_gen dut (
      .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .vid_en_frame(vid_en_frame),
      .free_run(free_run), .clk_hold(clk_hold), .div_m1(div_m1),
      .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1),
      .h_front_m1(h_front_m1), .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
      .v_act_m1(v_act_m1), .v_front_m1(v_front_m1), .lc_thresh(lc_thresh),
      .irq_en(irq_en), .irq_sel(irq_sel), .irq_clr(irq_clr),
      .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
      .hpos(hpos), .vpos(vpos), .lc_hit(lc_hit), .irq(irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // ---------------- reference model and scoreboard ----------------
   typedef struct {
      int ce, h, v, hs, vs, de, lc, irq;
   } item_t;
   item_t sb_q[$];

   int m_cnt, m_h, m_v, m_runq, m_stepq, m_fen, m_pend;

   function automatic int vstart(int sel);
      int s1 = v_sync_m1 + 1;
      int s2 = s1 + v_back_m1 + 1;
      int s3 = s2 + v_act_m1 + 1;
      case (sel)
         0: return 0;
         1: return s1;
         2: return s2;
         default: return s3;
      endcase
   endfunction

   always @(posedge clk) begin
      int tc, run, ce, adv, hwrap, ft, ev, fs;
      int hs2, hs3, htot, vs2, vs3, vtot;
      item_t it;
      hs2  = h_sync_m1 + h_back_m1 + 2;
      hs3  = hs2 + h_act_m1 + 1;
      htot = hs3 + h_front_m1 + 1;
      vs2  = vstart(2);
      vs3  = vstart(3);
      vtot = vs3 + v_front_m1 + 1;
      tc   = (div_m1 == 8'hFF) ? 254 : int'(div_m1);
      run  = (vid_en || free_run) ? 1 : 0;
      if (!rst_n) begin
         m_cnt = 0; m_h = 0; m_v = 0; m_runq = 0; m_stepq = 0; m_fen = 0; m_pend = 0;
      end else begin
         ce    = (run && !clk_hold && m_cnt >= tc) ? 1 : 0;
         adv   = (vid_en && ce) ? 1 : 0;
         hwrap = (adv && m_h >= htot - 1) ? 1 : 0;
         ft    = (vid_en && m_stepq && m_h == 0 && m_v == 0) ? 1 : 0;
         ev    = (vid_en && m_stepq && m_h == 0 && m_v == vstart(irq_sel)) ? 1 : 0;
         fs    = ((vid_en && !m_runq) || ft) ? 1 : 0;
         if (!run) m_cnt = 0;
         else if (clk_hold) m_cnt = m_cnt;
         else if (ce) m_cnt = 0;
         else m_cnt = m_cnt + 1;
         if (!vid_en) begin
            m_h = 0; m_v = 0;
         end else if (adv) begin
            m_h = hwrap ? 0 : m_h + 1;
            if (hwrap) m_v = (m_v >= vtot - 1) ? 0 : m_v + 1;
         end
         if (fs) m_fen = vid_en_frame;
         if (irq_en && ev) m_pend = 1;
         else if (irq_clr) m_pend = 0;
         m_runq  = vid_en;
         m_stepq = adv;
      end
      it.ce  = (run && !clk_hold && m_cnt >= tc) ? 1 : 0;
      it.h   = m_h;
      it.v   = m_v;
      it.hs  = (vid_en && m_h < h_sync_m1 + 1) ? 1 : 0;
      it.vs  = (vid_en && m_v < v_sync_m1 + 1) ? 1 : 0;
      it.de  = (vid_en && m_fen && m_h >= hs2 && m_h < hs3 && m_v >= vs2 && m_v < vs3) ? 1 : 0;
      it.lc  = (vid_en && m_v >= vs2 && m_v < vs3 && (m_v - vs2) == lc_thresh) ? 1 : 0;
      it.irq = m_pend;
      sb_q.push_back(it);
   end

   // Monitor: pop and compare away from the active edge.
   always @(negedge clk) begin
      item_t e;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk("R2/R3 pix_ce", pix_ce, e.ce);
         chk("R4 hpos", hpos, e.h);
         chk("R5 vpos", vpos, e.v);
         chk("R4 hsync", hsync, e.hs);
         chk("R5 vsync", vsync, e.vs);
         chk("R6 de", de, e.de);
         chk("R9 lc_hit", lc_hit, e.lc);
         chk("R10 irq", irq, e.irq);
      end
   end

   // ---------------- driver ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1;
      cyc(1);
      irq_clr = 1'b0;
   endtask

   initial begin
      h_sync_m1 = 1; h_back_m1 = 2; h_act_m1 = 7; h_front_m1 = 1;
      v_sync_m1 = 0; v_back_m1 = 1; v_act_m1 = 3; v_front_m1 = 0;
      cyc(3);
      // R1: reset state
      chk("R1 hpos", hpos, 0);
      chk("R1 irq", irq, 0);
      chk("R1 de", de, 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 pix_ce after release", pix_ce, 0);

      // Scenario A: divisor 1, vsync interrupt, frame enable on
      div_m1 = 0; irq_en = 1; irq_sel = 0; lc_thresh = 3; vid_en_frame = 1;
      vid_en = 1;
      cyc(260);
      pulse_clr();
      cyc(20);
      pulse_clr();

      // R7: drop frame enable mid-frame, de keeps going until frame start
      while (de !== 1'b1) cyc(1);
      vid_en_frame = 0;
      cyc(1);
      chk("R7 de unchanged mid-frame", de, 1);
      cyc(150);
      vid_en_frame = 1;
      cyc(130);

      // R8: disable clears position immediately
      vid_en = 0;
      cyc(1);
      chk("R8 hpos cleared", hpos, 0);
      chk("R8 hsync low", hsync, 0);

      // Scenario B: divisor 3, active-region interrupt, hold pulses
      div_m1 = 2; irq_sel = 2; lc_thresh = 2; pulse_clr();
      vid_en = 1;
      cyc(100);
      clk_hold = 1;
      cyc(7);
      chk("R3 hold blocks pix_ce", pix_ce, 0);
      clk_hold = 0;
      cyc(300);
      irq_sel = 1; pulse_clr();
      cyc(200);
      irq_sel = 3;
      cyc(200);

      // R11: interrupts masked
      vid_en = 0; irq_en = 0; pulse_clr();
      div_m1 = 0; vid_en = 1;
      cyc(400);
      chk("R11 irq stays low", irq, 0);

      // Scenario C: free-run divider with video off
      vid_en = 0; div_m1 = 1;
      free_run = 1;
      cyc(20);
      free_run = 0;
      cyc(4);
      chk("R3 idle pix_ce", pix_ce, 0);

      // R2: saturated divider period
      div_m1 = 8'hFF; vid_en = 1;
      begin
         int n = 0;
         while (pix_ce !== 1'b1) cyc(1);
         do begin
            cyc(1);
            n++;
         end while (pix_ce !== 1'b1 && n < 400);
         chk("R2 saturated period", n, 255);
      end
      cyc(600);

      vid_en = 0;
      cyc(3);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule